// File: doc/BRIEF.md
# Int8 Matrix-Vector Accumulate Engine

This block is the arithmetic core of a tensor accelerator. Every cycle it can take one command that carries a 16-element signed 8-bit vector and a 16x16 signed 8-bit weight tile. It forms the 16 row dot products of the tile with the vector and folds them into one of 64 accumulator vectors. Each accumulator vector has sixteen 32-bit lanes, and the command picks the vector by index. A second command kind clears an accumulator vector and does no arithmetic. A separate read-out port returns a whole accumulator vector.

The command port is a valid/ready stream. `cmd_ready` goes high on the first clock edge after reset and stays high, so the engine never applies back-pressure. A command is taken on every edge where `cmd_valid` and `cmd_ready` are both high. Work moves through two registered stages: multiply and reduce, then accumulate and write back. A command that targets an accumulator still being written by the command before it gets the newer value through a forwarding path, with no stall. The read port is a plain request/response pair: it has no ready signal and answers in a fixed number of cycles.

Top module: `mvacc_engine`

## Requirements
- R1: After reset every accumulator lane reads as zero and `rd_valid` is low.
- R2: From the first clock edge after reset, `cmd_ready` is high on every cycle, and one command is accepted per cycle with no back-pressure.
- R3: `cmd_op` value 0 selects zero-fill and value 1 selects accumulate.
- R4: For an accumulate, lane r receives the sum over c of W[r][c]*x[c], with all operands signed two's complement. x[c] is `cmd_vec[8c+7:8c]`, W[r][c] is `cmd_wgt[8(16r+c)+7:8(16r+c)]`, and lane r of read data is `rd_data[32r+31:32r]`.
- R5: An accumulate adds the full-precision dot product to the current lane contents with 32-bit wrap-around. It never overwrites them.
- R6: A zero-fill sets all 16 lanes of the selected accumulator to zero and leaves every other accumulator unchanged.
- R7: Commands to the same index in consecutive cycles take effect in command order (accumulate then accumulate, zero then accumulate, accumulate then zero), with no stall.
- R8: A read request sampled at an edge gives `rd_valid` high and the indexed vector on `rd_data` after the next edge. A command accepted at edge t is visible to a read request sampled at edge t+2 or later.
- R9: In a cycle after an edge with no read request, `rd_valid` is low and `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine accepts a command |
| cmd_op | input | 1 | 0 zero-fill, 1 accumulate |
| cmd_idx | input | 6 | Target accumulator index |
| cmd_vec | input | 128 | Input vector, 16 signed bytes |
| cmd_wgt | input | 2048 | Weight tile, 256 signed bytes, row-major |
| rd_req | input | 1 | Read request |
| rd_idx | input | 6 | Accumulator index to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 512 | Sixteen 32-bit accumulator lanes |

## Verification
The main function is driven with random signed tiles and vectors spread over many indices. This shows whether the lane and byte ordering and the sign handling are correct. Extreme operands (all +127, and -128 against +127) check that products and sums are sign-extended properly. A long run of back-to-back accumulates at maximum positive value pushes the lanes past 2^31, which shows whether the sum wraps at 32 bits or saturates. Consecutive same-index pairs in the three orderings separate correct forwarding from a stale base read, and a zero-fill next to an unrelated index shows that a clear is confined to its target.

// File: rtl/mv_pkg.sv
package mv_pkg;
  typedef enum logic {
    OP_ZERO = 1'b0,
    OP_ACC  = 1'b1
  } mv_op_e;
endpackage

// File: rtl/mv_dot_row.sv
// One row of the tile: signed dot product of a weight row with the vector.
module mv_dot_row #(
  parameter int LANES = 16,
  parameter int DW    = 8,
  parameter int SW    = 2 * DW + $clog2(LANES)
) (
  input  logic [LANES*DW-1:0] row_wgt,
  input  logic [LANES*DW-1:0] vec,
  output logic signed [SW-1:0] dot
);
  localparam int PW = 2 * DW;

  logic signed [SW-1:0] sum;
  logic signed [PW-1:0] prod;

  always_comb begin
    sum  = '0;
    prod = '0;
    for (int c = 0; c < LANES; c++) begin
      prod = $signed(row_wgt[c*DW +: DW]) * $signed(vec[c*DW +: DW]);
      sum  = sum + SW'(prod);
    end
    dot = sum;
  end
endmodule

// File: rtl/mv_acc_file.sv
// Accumulator register file: one write port, two combinational read ports.
module mv_acc_file #(
  parameter int DEPTH = 64,
  parameter int VW    = 512,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [VW-1:0]   wr_data,
  input  logic [IDXW-1:0] ra_idx,
  output logic [VW-1:0]   ra_data,
  input  logic [IDXW-1:0] rb_idx,
  output logic [VW-1:0]   rb_data
);
  logic [VW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
endmodule

// File: rtl/mvacc_engine.sv
module mvacc_engine #(
  parameter int LANES = 16,
  parameter int DW    = 8,
  parameter int AW    = 32,
  parameter int DEPTH = 64,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic                     cmd_op,
  input  logic [IDXW-1:0]          cmd_idx,
  input  logic [LANES*DW-1:0]      cmd_vec,
  input  logic [LANES*LANES*DW-1:0] cmd_wgt,
  input  logic                     rd_req,
  input  logic [IDXW-1:0]          rd_idx,
  output logic                     rd_valid,
  output logic [LANES*AW-1:0]      rd_data
);
  import mv_pkg::*;

  localparam int SW  = 2 * DW + $clog2(LANES);
  localparam int VW  = LANES * AW;
  localparam int RWW = LANES * DW;

  // Ready register: low in reset, high from the first edge afterwards.
  logic ready_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign cmd_ready = ready_q;

  logic accept;
  assign accept = cmd_valid && ready_q;

  // Stage one: multiply and reduce, one row module per output lane.
  logic [VW-1:0] dot_ext;
  for (genvar r = 0; r < LANES; r++) begin : g_row
    logic signed [SW-1:0] row_dot;
    mv_dot_row #(.LANES(LANES), .DW(DW), .SW(SW)) u_row (
      .row_wgt (cmd_wgt[r*RWW +: RWW]),
      .vec     (cmd_vec),
      .dot     (row_dot)
    );
    assign dot_ext[r*AW +: AW] = AW'(row_dot);
  end

  // Pipeline registers between the stages.
  logic            s1_valid;
  mv_op_e          s1_op;
  logic [IDXW-1:0] s1_idx;
  logic [VW-1:0]   s1_dot;
  logic [VW-1:0]   s1_base;

  // Stage two: accumulate or clear, then write back.
  logic [VW-1:0] wr_value;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wr_value[l*AW +: AW] = (s1_op == OP_ACC)
                                  ? (s1_base[l*AW +: AW] + s1_dot[l*AW +: AW])
                                  : '0;
  end

  logic [VW-1:0] file_a;
  logic [VW-1:0] file_b;

  mv_acc_file #(.DEPTH(DEPTH), .VW(VW), .IDXW(IDXW)) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (s1_valid),
    .wr_idx  (s1_idx),
    .wr_data (wr_value),
    .ra_idx  (cmd_idx),
    .ra_data (file_a),
    .rb_idx  (rd_idx),
    .rb_data (file_b)
  );

  // Base read with forwarding from the write that lands on the same edge.
  logic [VW-1:0] base_next;
  assign base_next = (s1_valid && (s1_idx == cmd_idx)) ? wr_value : file_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_ZERO;
      s1_idx   <= '0;
      s1_dot   <= '0;
      s1_base  <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_op   <= mv_op_e'(cmd_op);
        s1_idx  <= cmd_idx;
        s1_dot  <= dot_ext;
        s1_base <= base_next;
      end
    end
  end

  // Read-out port: one registered cycle, data held between requests.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= file_b;
    end
  end
endmodule

// File: rtl/mvacc_engine_checker.sv
module mvacc_engine_checker #(
  parameter int IDXW = 6,
  parameter int VW   = 512
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic            cmd_op,
  input logic [IDXW-1:0] cmd_idx,
  input logic            rd_req,
  input logic [IDXW-1:0] rd_idx,
  input logic            rd_valid,
  input logic [VW-1:0]   rd_data
);
  import mv_pkg::*;

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  logic zero_acc;
  assign zero_acc = cmd_valid && cmd_ready && (cmd_op == OP_ZERO);

  // R2: no back-pressure once out of reset
  a_r2_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0) |-> cmd_ready);

  // R8: a read request is answered on the next cycle
  a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R9: no request, no valid, data held
  a_r9_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!rd_valid && $stable(rd_data)));

  // R6: a zero-fill read two cycles later returns all zero lanes
  a_r6_zero_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm == 2'd3) && rd_valid && $past(zero_acc, 3) &&
     ($past(cmd_idx, 3) == $past(rd_idx, 1))) |-> (rd_data == '0));
endmodule

bind mvacc_engine mvacc_engine_checker #(.IDXW(IDXW), .VW(LANES*AW)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_idx   (cmd_idx),
  .rd_req    (rd_req),
  .rd_idx    (rd_idx),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data)
);

// File: tb/tb_mvacc_engine.sv
module tb_mvacc_engine;
  localparam int CLK_PERIOD = 10;
  localparam int L     = 16;
  localparam int DW    = 8;
  localparam int AW    = 32;
  localparam int DEPTH = 64;
  localparam int IW    = 6;
  localparam int VW    = L * DW;
  localparam int WW    = L * L * DW;
  localparam int LW    = L * AW;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_op = 1'b0;
  logic [IW-1:0] cmd_idx = '0;
  logic [VW-1:0] cmd_vec = '0;
  logic [WW-1:0] cmd_wgt = '0;
  logic          rd_req = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic          rd_valid;
  logic [LW-1:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  mvacc_engine dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_vec(cmd_vec), .cmd_wgt(cmd_wgt),
    .rd_req(rd_req), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [LW-1:0] model [DEPTH];
  logic [LW-1:0] exp_q [$];
  string         tag_q [$];
  bit            last_was_cmd = 1'b0;

  function automatic logic [LW-1:0] mac_row(input logic [LW-1:0] base,
                                             input logic [VW-1:0] v,
                                             input logic [WW-1:0] w);
    logic [LW-1:0] res;
    for (int r = 0; r < L; r++) begin
      int s = 0;
      for (int c = 0; c < L; c++)
        s += $signed(w[(r*L+c)*DW +: DW]) * $signed(v[c*DW +: DW]);
      res[r*AW +: AW] = base[r*AW +: AW] + 32'(s);
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one command per call, model updated in command order.
  task automatic issue(input logic op, input logic [IW-1:0] idx,
                       input logic [VW-1:0] v, input logic [WW-1:0] w, input string tag);
    @(negedge clk);
    check({tag, " R2 ready"}, LW'(cmd_ready), LW'(1'b1));
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_vec = v; cmd_wgt = w;
    rd_req = 1'b0;
    model[idx] = op ? mac_row(model[idx], v, w) : '0;
    last_was_cmd = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = 1'b0; rd_req = 1'b0;
    last_was_cmd = 1'b0;
  endtask

  task automatic read(input logic [IW-1:0] idx, input string tag);
    if (last_was_cmd) idle();
    @(negedge clk);
    cmd_valid = 1'b0; rd_req = 1'b1; rd_idx = idx;
    exp_q.push_back(model[idx]);
    tag_q.push_back(tag);
  endtask

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int c = 0; c < L; c++) v[c*DW +: DW] = 8'($urandom);
    return v;
  endfunction

  function automatic logic [WW-1:0] rand_wgt();
    logic [WW-1:0] w;
    for (int c = 0; c < L*L; c++) w[c*DW +: DW] = 8'($urandom);
    return w;
  endfunction

  function automatic logic [VW-1:0] fill_vec(input logic [7:0] b);
    logic [VW-1:0] v;
    for (int c = 0; c < L; c++) v[c*DW +: DW] = b;
    return v;
  endfunction

  function automatic logic [WW-1:0] fill_wgt(input logic [7:0] b);
    logic [WW-1:0] w;
    for (int c = 0; c < L*L; c++) w[c*DW +: DW] = b;
    return w;
  endfunction

  // Monitor: compares each read response against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 unexpected rd_valid actual=1 expected=0");
      end else begin
        logic [LW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [LW-1:0] held;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rd_valid after reset", LW'(rd_valid), LW'(1'b0));
    read(6'd0,  "R1 index 0 zero");
    read(6'd63, "R1 index 63 zero");

    // R4 R5: random accumulates, several into the same vectors
    for (int k = 0; k < 24; k++)
      issue(1'b1, IW'(k % 8), rand_vec(), rand_wgt(), "R4 random");
    for (int i = 0; i < 8; i++) read(IW'(i), "R4 R5 random accumulate");

    // R4: sign extremes
    issue(1'b1, 6'd20, fill_vec(8'h7f), fill_wgt(8'h7f), "R4 max");
    issue(1'b1, 6'd21, fill_vec(8'h7f), fill_wgt(8'h80), "R4 min");
    issue(1'b1, 6'd22, fill_vec(8'h80), fill_wgt(8'h80), "R4 neg neg");
    read(6'd20, "R4 all +127");
    read(6'd21, "R4 -128 by +127");
    read(6'd22, "R4 -128 by -128");

    // R3 R6: zero-fill clears target only
    issue(1'b0, 6'd3, rand_vec(), rand_wgt(), "R6 zero");
    read(6'd3, "R3 R6 zero-fill target");
    read(6'd4, "R6 neighbour untouched");

    // R7: back-to-back orderings on one index
    issue(1'b1, 6'd30, rand_vec(), rand_wgt(), "R7");
    issue(1'b1, 6'd30, rand_vec(), rand_wgt(), "R7");
    issue(1'b1, 6'd30, rand_vec(), rand_wgt(), "R7");
    read(6'd30, "R7 acc acc acc forwarding");
    issue(1'b1, 6'd31, rand_vec(), rand_wgt(), "R7");
    issue(1'b0, 6'd31, rand_vec(), rand_wgt(), "R7");
    issue(1'b1, 6'd31, rand_vec(), rand_wgt(), "R7");
    read(6'd31, "R7 acc zero acc ordering");
    issue(1'b1, 6'd32, rand_vec(), rand_wgt(), "R7");
    issue(1'b0, 6'd32, rand_vec(), rand_wgt(), "R7");
    read(6'd32, "R7 acc then zero");

    // R8: visibility two edges after acceptance, back-to-back reads
    issue(1'b1, 6'd40, rand_vec(), rand_wgt(), "R8");
    read(6'd40, "R8 visible after two edges");
    read(6'd30, "R8 back-to-back read");

    // R9: data held without request
    idle(); idle();
    held = rd_data;
    idle(); idle();
    check("R9 rd_valid idle", LW'(rd_valid), LW'(1'b0));
    check("R9 rd_data held", rd_data, held);

    // R5: long accumulate run past 2^31 to show 32-bit wrap
    for (int k = 0; k < 8400; k++)
      issue(1'b1, 6'd50, fill_vec(8'h7f), fill_wgt(8'h7f), "R5 wrap");
    read(6'd50, "R5 32-bit wrap-around");

    repeat (4) idle();
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8 missing responses actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule